// File: doc/BRIEF.md
# Serial SRAM Slave Front End

This block is the slave side of a four-wire serial link that gives a host access to a 32K x 8 on-chip memory. The host lowers chip select, clocks in an instruction byte and then an address or a data byte. The block decodes four instructions: memory read, memory write, configuration read and configuration write. It drives a synchronous single-port RAM. Serial clock, chip select and serial input are synchronised into the system clock domain and turned into one-cycle edge strobes. Serial output comes from a register with a separate drive enable that a pad cell uses to tri-state the line.

Memory transfers keep going for as long as the host keeps clocking. The block does not work out the next address itself. After each data byte it loads whatever address a neighbouring sequencer offers on `seq_next_addr`. The sequencer works from the current `mem_addr` and the two-bit mode the block exports on `cfg_mode`. The RAM port has a fixed latency and no back-pressure: a write is a one-cycle `mem_we` strobe, and `mem_rdata` must show the word at `mem_addr` one clock after the address is presented. The serial clock's low and high phases must each last at least six system clocks.

Top module: `sram_spi_front`

## Requirements
- R1: Instruction bytes are decoded as 0x03 memory read, 0x02 memory write, 0x05 configuration read and 0x01 configuration write. Any other byte makes the block ignore the rest of the frame: no RAM write, no configuration change, and the output is never enabled.
- R2: Every field is shifted most significant bit first. The serial input is sampled on the rising serial clock edge, and `spi_miso` changes only in the cycle after a synchronised falling edge.
- R3: After a memory instruction, two address bytes follow. Bit 15 of that 16-bit field is ignored, so 0xFFFE selects word 0x7FFE.
- R4: `spi_miso_oe` is low whenever chip select is high. It goes high only during a memory read or a configuration read. A rising chip select ends any transfer and returns the block to waiting for an instruction.
- R5: A write data byte reaches the RAM as a single-cycle `mem_we` strobe only once all eight of its bits have arrived. A partial byte cut off by chip select is dropped.
- R6: For a read, the RAM address is loaded as soon as the last address bit is sampled. The first data bit (bit 7) appears on `spi_miso` after the next falling serial clock edge.
- R7: A configuration write sets the mode field from data bits [7:6] (00 single word, 10 page, 01 burst) and the hold-disable flag from bit 0. All other bits read back as zero. Writing 11 to the mode field leaves the previous mode unchanged. The configuration changes at no other time.
- R8: The configuration byte reads back as {mode[1:0], 5'b0, hold_disable} after instruction 0x05. It is 0x00 after reset.
- R9: After each memory data byte (written or read out), `mem_addr` loads `seq_next_addr`. This lets single-word, page-wrap and burst-wrap streaming all follow the exported mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso` |
| mem_addr | output | ADDR_W | RAM word address |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after address |
| seq_next_addr | input | ADDR_W | Next address from the sequencer |
| cfg_mode | output | 2 | Stream mode field of the configuration byte |
| cfg_nohold | output | 1 | Hold-disable flag of the configuration byte |

## Verification
The bound checker checks five things on every clock:
- the output enable drops after chip select rises;
- `spi_miso` moves only after a falling-edge strobe;
- write strobes last exactly one cycle;
- each write is followed by a load of the sequencer's address;
- the configuration changes only on a decoded configuration write.

Instruction decoding, MSB-first ordering, the ignored address bit, the first-bit timing of reads, and page and burst wrap can only be shown by scenarios. The same goes for the loss of a partial byte and the rule that mode 11 is kept out. The bench shows them by writing through the serial link and reading the data back.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDCFG = 8'h05;
  localparam logic [7:0] OP_WRCFG = 8'h01;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_WDATA, PH_RDATA, PH_CFGW, PH_CFGR, PH_SKIP
  } phase_t;

  localparam logic [1:0] MODE_KEEP = 2'b11;
endpackage

// File: rtl/sram_spi_sync.sv
module sram_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic mosi_s
);
  localparam logic [2:0] RST_V = 3'b010;  // {sck, cs_n, mosi}

  logic [2:0] pipe [STAGES];
  logic       sck_prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[g] <= RST_V;
        else        pipe[g] <= {sck_in, cs_n_in, mosi_in};
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[g] <= RST_V;
        else        pipe[g] <= pipe[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= pipe[STAGES-1][2];

  assign cs_act   = ~pipe[STAGES-1][1];
  assign mosi_s   =  pipe[STAGES-1][0];
  assign sck_rise = cs_act &  pipe[STAGES-1][2] & ~sck_prev;
  assign sck_fall = cs_act & ~pipe[STAGES-1][2] &  sck_prev;
endmodule

// File: rtl/sram_spi_cfg.sv
module sram_spi_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_bits,   // {mode[1:0], hold_disable}
  output logic [7:0] cfg_q,
  output logic [1:0] mode,
  output logic       nohold
);
  import sram_spi_pkg::*;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode   <= 2'b00;
      nohold <= 1'b0;
    end else if (wr_en) begin
      if (wr_bits[2:1] != MODE_KEEP) mode <= wr_bits[2:1];
      nohold <= wr_bits[0];
    end

  assign cfg_q = {mode, 5'b00000, nohold};
endmodule

// File: rtl/sram_spi_tx.sv
module sram_spi_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_fall,
  input  logic       cs_act,
  input  logic       en,
  input  logic [7:0] src,
  output logic       so,
  output logic       oe,
  output logic       byte_done
);
  logic [6:0] rest;
  logic [2:0] fcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      so <= 1'b0; oe <= 1'b0; rest <= '0; fcnt <= '0; byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!cs_act) begin
        oe   <= 1'b0;
        fcnt <= '0;
      end else if (en && sck_fall) begin
        oe   <= 1'b1;
        fcnt <= fcnt + 3'd1;
        if (fcnt == 3'd0) begin
          so   <= src[7];
          rest <= src[6:0];
        end else begin
          so   <= rest[6];
          rest <= {rest[5:0], 1'b0};
        end
        if (fcnt == 3'd7) byte_done <= 1'b1;
      end
    end
endmodule

// File: rtl/sram_spi_front.sv
module sram_spi_front #(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic [ADDR_W-1:0] seq_next_addr,
  output logic [1:0]        cfg_mode,
  output logic              cfg_nohold
);
  import sram_spi_pkg::*;

  localparam int CNT_W = 5;

  logic              sck_rise, sck_fall, cs_act, mosi_s;
  phase_t            ph;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] rx, rx_nx;
  logic              is_read;
  logic              sr_wr;
  logic [7:0]        cfg_q;
  logic              tx_en, tx_done;
  logic [7:0]        tx_src;

  sram_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(spi_sck), .cs_n_in(spi_cs_n),
    .mosi_in(spi_mosi), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_act(cs_act), .mosi_s(mosi_s)
  );

  assign rx_nx = (rx << 1) | ADDR_W'(mosi_s);
  assign sr_wr = sck_rise && (ph == PH_CFGW) && (cnt == CNT_W'(7));

  sram_spi_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(sr_wr),
    .wr_bits({rx_nx[7:6], rx_nx[0]}),
    .cfg_q(cfg_q), .mode(cfg_mode), .nohold(cfg_nohold)
  );

  assign tx_en  = (ph == PH_RDATA) || (ph == PH_CFGR);
  assign tx_src = (ph == PH_CFGR) ? cfg_q : mem_rdata;

  sram_spi_tx u_tx (
    .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .cs_act(cs_act),
    .en(tx_en), .src(tx_src), .so(spi_miso), .oe(spi_miso_oe),
    .byte_done(tx_done)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph <= PH_CMD; cnt <= '0; rx <= '0; is_read <= 1'b0;
      mem_addr <= '0; mem_we <= 1'b0; mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (mem_we || (tx_done && ph == PH_RDATA)) mem_addr <= seq_next_addr;
      if (!cs_act) begin
        ph  <= PH_CMD;
        cnt <= '0;
      end else if (sck_rise) begin
        rx  <= rx_nx;
        cnt <= cnt + CNT_W'(1);
        case (ph)
          PH_CMD: if (cnt == CNT_W'(7)) begin
            cnt <= '0;
            case (rx_nx[7:0])
              OP_READ:  begin ph <= PH_ADDR; is_read <= 1'b1; end
              OP_WRITE: begin ph <= PH_ADDR; is_read <= 1'b0; end
              OP_RDCFG: ph <= PH_CFGR;
              OP_WRCFG: ph <= PH_CFGW;
              default:  ph <= PH_SKIP;
            endcase
          end
          PH_ADDR: if (cnt == CNT_W'(15)) begin
            cnt      <= '0;
            mem_addr <= rx_nx;
            ph       <= is_read ? PH_RDATA : PH_WDATA;
          end
          PH_WDATA: if (cnt == CNT_W'(7)) begin
            cnt       <= '0;
            mem_we    <= 1'b1;
            mem_wdata <= rx_nx[7:0];
          end
          PH_CFGW: if (cnt == CNT_W'(7)) ph <= PH_SKIP;
          default: cnt <= '0;
        endcase
      end
    end
endmodule

// File: rtl/sram_spi_front_chk.sv
module sram_spi_front_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              sck_fall,
  input logic              sr_wr,
  input logic              spi_miso,
  input logic              spi_miso_oe,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] seq_next_addr,
  input logic [1:0]        cfg_mode,
  input logic              cfg_nohold
);
  assert_hiz_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso_oe);

  assert_so_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(spi_miso));

  assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_addr_follows_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == $past(seq_next_addr)));

  assert_cfg_only_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_wr |=> $stable({cfg_mode, cfg_nohold}));
endmodule

bind sram_spi_front sram_spi_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_fall(sck_fall),
  .sr_wr(sr_wr), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
  .mem_we(mem_we), .mem_addr(mem_addr), .seq_next_addr(seq_next_addr),
  .cfg_mode(cfg_mode), .cfg_nohold(cfg_nohold)
);

// File: tb/tb_sram_spi_front.sv
`timescale 1ns/1ps
module tb_sram_spi_front;
  localparam int AW   = 15;
  localparam int HALF = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe, mem_we, cfg_nohold;
  logic [AW-1:0] mem_addr, seq_next_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [1:0] cfg_mode;

  int n_chk = 0, n_err = 0, we_cnt = 0;
  logic oe_seen = 1'b0;
  logic [7:0] ram [int];

  always #5 clk = ~clk;

  sram_spi_front dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .seq_next_addr(seq_next_addr),
    .cfg_mode(cfg_mode), .cfg_nohold(cfg_nohold)
  );

  // bench RAM and address sequencer models
  always @(posedge clk) begin
    mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
    if (mem_we) begin
      ram[int'(mem_addr)] = mem_wdata;
      we_cnt++;
    end
    if (spi_miso_oe) oe_seen = 1'b1;
  end

  always_comb begin
    case (cfg_mode)
      2'b01:   seq_next_addr = mem_addr + 1'b1;
      2'b10:   seq_next_addr = {mem_addr[AW-1:5], mem_addr[4:0] + 5'd1};
      default: seq_next_addr = mem_addr;
    endcase
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] tb, input int nb, output logic [7:0] rb);
    rb = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      spi_mosi = tb[i];
      #(HALF);
      rb[i] = spi_miso;
      spi_sck = 1'b1;
      #(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tb, output logic [7:0] rb);
    xbits(tb, 8, rb);
  endtask

  task automatic cs_on();
    spi_cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic cs_off();
    #(HALF);
    spi_cs_n = 1'b1;
    #(2*HALF);
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    logic [7:0] d;
    cs_on(); xfer(8'h01, d); xfer(v, d); cs_off();
  endtask

  task automatic rd_cfg(output logic [7:0] v);
    logic [7:0] d;
    cs_on(); xfer(8'h05, d); xfer(8'h00, v); cs_off();
  endtask

  task automatic mem_start(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] d;
    cs_on(); xfer(op, d); xfer(a[15:8], d); xfer(a[7:0], d);
  endtask

  // {written configuration byte, expected read-back}
  localparam logic [15:0] CFG_TBL [6] = '{
    16'h8080, 16'hC181, 16'h7E40, 16'hFF41, 16'h0000, 16'h3D01
  };

  initial begin
    #(1_500_000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] r, d;
    int we0;
    #(100);
    rst_n = 1'b1;
    #(100);

    // reset state
    check("R4 reset oe", spi_miso_oe, 0);
    check("R5 reset we", mem_we, 0);
    check("R7 reset mode", cfg_mode, 0);
    rd_cfg(r);
    check("R8 reset cfg", r, 8'h00);

    // configuration table
    foreach (CFG_TBL[i]) begin
      wr_cfg(CFG_TBL[i][15:8]);
      rd_cfg(r);
      check("R7 R8 cfg readback", r, CFG_TBL[i][7:0]);
      check("R7 cfg_mode port", cfg_mode, CFG_TBL[i][7:6]);
    end

    // burst write across top of array, address bit 15 set (ignored)
    wr_cfg(8'h40);
    mem_start(8'h02, 16'hFFFE);
    xfer(8'hA5, d); xfer(8'h3C, d); xfer(8'hC3, d);
    cs_off();
    check("R3 top bit ignored word 0", ram[0], 8'hC3);
    mem_start(8'h03, 16'h7FFE);
    xfer(8'h00, r); check("R6 first read byte", r, 8'hA5);
    check("R4 oe during read", spi_miso_oe, 1);
    xfer(8'h00, r); check("R9 burst next byte", r, 8'h3C);
    xfer(8'h00, r); check("R2 R9 burst wrap", r, 8'hC3);
    cs_off();
    check("R4 oe after cs high", spi_miso_oe, 0);

    // page mode wrap within 32 words
    wr_cfg(8'h80);
    mem_start(8'h02, 16'h001F);
    xfer(8'h11, d); xfer(8'h22, d);
    cs_off();
    mem_start(8'h03, 16'h001E);
    xfer(8'h00, r); check("R9 page read 1E", r, 8'h00);
    xfer(8'h00, r); check("R9 page read 1F", r, 8'h11);
    xfer(8'h00, r); check("R9 page wrap to 00", r, 8'h22);
    cs_off();

    // partial byte dropped
    wr_cfg(8'h40);
    we0 = we_cnt;
    mem_start(8'h02, 16'h0100);
    xfer(8'h5A, d);
    xbits(8'hF0, 4, d);
    cs_off();
    check("R5 one strobe for partial frame", we_cnt - we0, 1);
    mem_start(8'h03, 16'h0100);
    xfer(8'h00, r); check("R5 full byte stored", r, 8'h5A);
    xfer(8'h00, r); check("R5 partial byte dropped", r, 8'h00);
    cs_off();

    // unknown instruction ignored
    we0 = we_cnt;
    oe_seen = 1'b0;
    cs_on(); xfer(8'h00, d); xfer(8'hFF, d); xfer(8'hFF, d); xfer(8'hFF, d); cs_off();
    check("R1 no write on unknown op", we_cnt - we0, 0);
    check("R1 no drive on unknown op", oe_seen, 0);
    rd_cfg(r);
    check("R1 cfg untouched", r, 8'h40);

    // single-word mode: sequencer holds address
    wr_cfg(8'h00);
    mem_start(8'h03, 16'h0100);
    xfer(8'h00, r); check("R9 word read", r, 8'h5A);
    xfer(8'h00, r); check("R9 word repeat", r, 8'h5A);
    cs_off();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule